// File: doc/BRIEF.md
# Serial Programming Command Decoder

This block is the command front end of a serial programming port. It is active only while its programming-reset input is held low. A host clocks 4-byte instructions in on a serial clock and data line. The block frames those bits into bytes and bytes into instructions, counting from the moment the programming reset went low. On the data return line it sends back the byte it has just received, delayed by one byte. A host can therefore see whether the device is aligned with its framing.

Nothing is accepted until the host has sent an unlock instruction. That instruction starts with 0xAC, and its second byte is 0x53. When the unlock works, the 0x53 comes back on the return line while the third byte goes in. If the host does not see the 0x53, it gives one extra clock pulse to move the framing by one bit and tries again. Once unlocked, the block turns an erase instruction into a single-cycle request to the memory controller.

The serial clock and data inputs are resynchronised to the system clock, and every decision is made in the system clock domain. Each serial clock phase must last at least two system clocks.

Top module: `ispCmdDecoder`

## Requirements
- R1: While progResetN is high, progEnabled, eraseReq and misoOut are 0. Serial clock edges have no effect, and bit and byte framing starts afresh when progResetN goes low.
- R2: mosiIn is sampled on each rising edge of sckIn, most significant bit first. Every 8 rising edges form one byte, and every 4 bytes form one instruction.
- R3: An instruction whose byte 0 is 0xAC and whose byte 1 is 0x53 sets progEnabled once its last bit has been received. Bytes 2 and 3 are don't-care.
- R4: During each byte, misoOut presents the byte received just before it, most significant bit first. It updates on falling edges of sckIn. During the first byte of a session misoOut is 0.
- R5: While progEnabled is 1, an instruction whose byte 0 is 0xAC and whose byte 1 has 100 in bits 7:5 produces exactly one single-cycle eraseReq pulse after its last bit.
- R6: An erase instruction received while progEnabled is 0 produces no eraseReq and leaves progEnabled at 0.
- R7: An unlock attempt whose byte 1 is not 0x53 leaves progEnabled at 0. A single extra sckIn pulse moves the framing by one bit, and a later aligned unlock then succeeds.
- R8: Once set, progEnabled stays 1 whatever instructions follow, until progResetN goes high.
- R9: eraseReq is never wider than one cycle and is never 1 while progEnabled is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| progResetN | input | 1 | Programming reset; the block is active while this is low |
| sckIn | input | 1 | Serial clock from the host (asynchronous) |
| mosiIn | input | 1 | Serial data from the host (asynchronous) |
| misoOut | output | 1 | Echo data returned to the host |
| progEnabled | output | 1 | Programming unlocked for this session |
| eraseReq | output | 1 | Single-cycle erase request to the memory controller |

## Verification
On every cycle the assertions check four things. The outputs clear in the cycle after progResetN rises. The unlock status holds while the session lasts. An erase request is always one cycle wide and only appears while unlocked. Framing, the one-byte-delayed echo, unlock and erase decoding, and recovery after a one-bit slip depend on whole bit streams. The bench covers these by playing random and directed streams, including stray clock pulses, and comparing against a bit-level model of the framing.

// File: rtl/ispPkg.sv
package ispPkg;
  localparam int BYTE_W = 8;

  // control to datapath
  typedef struct packed {
    logic sessionClr;
  } ctlStrobes_t;

  // datapath to control
  typedef struct packed {
    logic              byteDone;
    logic [BYTE_W-1:0] byteVal;
  } byteEvent_t;
endpackage

// File: rtl/ispShiftPath.sv
module ispShiftPath
  import ispPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sckIn,
  input  logic        mosiIn,
  input  ctlStrobes_t ctl,
  output byteEvent_t  byteEv,
  output logic        misoOut
);
  localparam int BIT_CNT_W = $clog2(BYTE_W);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] sckSync, mosiSync;
  logic                   sckLast;
  logic                   sckNow, mosiNow, sckRise, sckFall;
  logic [BIT_CNT_W-1:0]   bitCnt;
  logic [BYTE_W-1:0]      rxShift, echoByte, nextByte;

  // two or more flops per asynchronous input
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync  <= '0;
      mosiSync <= '0;
      sckLast  <= 1'b0;
    end else begin
      sckSync  <= {sckSync[SYNC_STAGES-2:0], sckIn};
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], mosiIn};
      sckLast  <= sckSync[SYNC_STAGES-1];
    end
  end

  assign sckNow   = sckSync[SYNC_STAGES-1];
  assign mosiNow  = mosiSync[SYNC_STAGES-1];
  assign sckRise  = sckNow & ~sckLast & ~ctl.sessionClr;
  assign sckFall  = ~sckNow & sckLast & ~ctl.sessionClr;
  assign nextByte = {rxShift[BYTE_W-2:0], mosiNow};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      rxShift  <= '0;
      echoByte <= '0;
      misoOut  <= 1'b0;
      byteEv   <= '0;
    end else if (ctl.sessionClr) begin
      bitCnt   <= '0;
      rxShift  <= '0;
      echoByte <= '0;
      misoOut  <= 1'b0;
      byteEv   <= '0;
    end else begin
      byteEv.byteDone <= 1'b0;
      if (sckRise) begin
        rxShift <= nextByte;
        if (bitCnt == LAST_BIT) begin
          bitCnt          <= '0;
          byteEv.byteDone <= 1'b1;
          byteEv.byteVal  <= nextByte;
          echoByte        <= nextByte;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
      if (sckFall) begin
        misoOut <= echoByte[LAST_BIT - bitCnt];
      end
    end
  end
endmodule

// File: rtl/ispFrameCtl.sv
module ispFrameCtl
  import ispPkg::*;
#(
  parameter int              FRAME_BYTES = 4,
  parameter logic [BYTE_W-1:0] UNLOCK_OP  = 8'hAC,
  parameter logic [BYTE_W-1:0] UNLOCK_KEY = 8'h53,
  parameter logic [2:0]      ERASE_TAG   = 3'b100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        progResetN,
  input  byteEvent_t  byteEv,
  output ctlStrobes_t ctl,
  output logic        progEnabled,
  output logic        eraseReq
);
  localparam int IDX_W = $clog2(FRAME_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

  logic [IDX_W-1:0]  byteIdx;
  logic [BYTE_W-1:0] opByte, argByte;
  logic              isUnlock, isErase;

  assign ctl.sessionClr = progResetN;
  assign isUnlock = (opByte == UNLOCK_OP) && (argByte == UNLOCK_KEY);
  assign isErase  = (opByte == UNLOCK_OP) && (argByte[BYTE_W-1 -: 3] == ERASE_TAG);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteIdx     <= '0;
      opByte      <= '0;
      argByte     <= '0;
      progEnabled <= 1'b0;
      eraseReq    <= 1'b0;
    end else if (progResetN) begin
      byteIdx     <= '0;
      opByte      <= '0;
      argByte     <= '0;
      progEnabled <= 1'b0;
      eraseReq    <= 1'b0;
    end else begin
      eraseReq <= 1'b0;
      if (byteEv.byteDone) begin
        if (byteIdx == '0) opByte <= byteEv.byteVal;
        if (byteIdx == IDX_W'(1)) argByte <= byteEv.byteVal;
        if (byteIdx == LAST_IDX) begin
          byteIdx <= '0;
          if (isUnlock) progEnabled <= 1'b1;
          if (progEnabled && isErase) eraseReq <= 1'b1;
        end else begin
          byteIdx <= byteIdx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ispCmdDecoder.sv
module ispCmdDecoder
  import ispPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BYTES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic progResetN,
  input  logic sckIn,
  input  logic mosiIn,
  output logic misoOut,
  output logic progEnabled,
  output logic eraseReq
);
  ctlStrobes_t ctl;
  byteEvent_t  byteEv;

  ispShiftPath #(.SYNC_STAGES(SYNC_STAGES)) uPath (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .mosiIn(mosiIn),
    .ctl(ctl), .byteEv(byteEv), .misoOut(misoOut)
  );

  ispFrameCtl #(.FRAME_BYTES(FRAME_BYTES)) uCtl (
    .clk(clk), .rstN(rstN), .progResetN(progResetN), .byteEv(byteEv),
    .ctl(ctl), .progEnabled(progEnabled), .eraseReq(eraseReq)
  );
endmodule

// File: rtl/ispCmdDecoderChk.sv
module ispCmdDecoderChk (
  input logic clk,
  input logic rstN,
  input logic progResetN,
  input logic misoOut,
  input logic progEnabled,
  input logic eraseReq
);
  // R1
  idle_outputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    progResetN |=> (!progEnabled && !eraseReq && !misoOut));

  // R8
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (progEnabled && !progResetN) |=> progEnabled);

  // R9
  erase_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    eraseReq |=> !eraseReq);

  // R6
  erase_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    eraseReq |-> progEnabled);
endmodule

bind ispCmdDecoder ispCmdDecoderChk uChk (
  .clk(clk), .rstN(rstN), .progResetN(progResetN),
  .misoOut(misoOut), .progEnabled(progEnabled), .eraseReq(eraseReq)
);

// File: tb/tb_ispCmdDecoder.sv
module tb_ispCmdDecoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic progResetN = 1'b1;
  logic sckIn = 1'b0;
  logic mosiIn = 1'b0;
  logic misoOut, progEnabled, eraseReq;

  int checks = 0;
  int errors = 0;
  int eraseSeen = 0;

  // bench model of the framing
  int       mBit = 0;
  int       mIdx = 0;
  logic [7:0] mShift = '0, mPrev = '0, mB0 = '0, mB1 = '0;
  logic     mEn = 1'b0;
  int       mErase = 0;
  logic     mActive = 1'b0;

  always #10 clk = ~clk;

  ispCmdDecoder dut (
    .clk(clk), .rstN(rstN), .progResetN(progResetN), .sckIn(sckIn),
    .mosiIn(mosiIn), .misoOut(misoOut), .progEnabled(progEnabled),
    .eraseReq(eraseReq)
  );

  always @(posedge clk) if (eraseReq) eraseSeen <= eraseSeen + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic expMiso();
    if (!mActive) return 1'b0;
    return mPrev[7 - mBit];
  endfunction

  // returns 1 when a frame completed
  function automatic logic modelBit(input logic b);
    logic [7:0] nb;
    logic fin;
    fin = 1'b0;
    if (!mActive) return 1'b0;
    nb = {mShift[6:0], b};
    mShift = nb;
    mBit++;
    if (mBit == 8) begin
      mBit = 0;
      mPrev = nb;
      if (mIdx == 0) mB0 = nb;
      if (mIdx == 1) mB1 = nb;
      if (mIdx == 3) begin
        mIdx = 0;
        fin = 1'b1;
        if (mEn && mB0 == 8'hAC && mB1[7:5] == 3'b100) mErase++;
        if (mB0 == 8'hAC && mB1 == 8'h53) mEn = 1'b1;
      end else begin
        mIdx++;
      end
    end
    return fin;
  endfunction

  task automatic sendBit(input logic b, input string tag);
    logic fin;
    @(negedge clk);
    mosiIn = b;
    repeat (3) @(negedge clk);
    check({tag, " R2 R4 echo bit"}, int'(misoOut), int'(expMiso()));
    sckIn = 1'b1;
    repeat (6) @(negedge clk);
    sckIn = 1'b0;
    repeat (6) @(negedge clk);
    fin = modelBit(b);
    if (fin) begin
      check({tag, " R3 R8 enabled"}, int'(progEnabled), int'(mEn));
      check({tag, " R5 erase count"}, eraseSeen, mErase);
    end
  endtask

  task automatic sendByte(input logic [7:0] v, input string tag);
    for (int i = 7; i >= 0; i--) sendBit(v[i], tag);
  endtask

  task automatic sendFrame(input logic [7:0] a, input logic [7:0] b,
                           input logic [7:0] c, input logic [7:0] d,
                           input string tag);
    sendByte(a, tag); sendByte(b, tag); sendByte(c, tag); sendByte(d, tag);
  endtask

  task automatic startSession();
    @(negedge clk);
    progResetN = 1'b0;
    mActive = 1'b1;
    mBit = 0; mIdx = 0; mShift = '0; mPrev = '0; mB0 = '0; mB1 = '0;
    mEn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic endSession();
    @(negedge clk);
    progResetN = 1'b1;
    mActive = 1'b0;
    mEn = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 enable cleared", int'(progEnabled), 0);
    check("R1 miso cleared", int'(misoOut), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset enabled", int'(progEnabled), 0);
    check("R1 reset erase", int'(eraseReq), 0);
    check("R1 reset miso", int'(misoOut), 0);

    // inactive: clock activity must be ignored
    sendFrame(8'hAC, 8'h53, 8'h00, 8'h00, "R1 inactive");
    check("R1 unlock ignored while inactive", int'(progEnabled), 0);
    check("R1 miso quiet while inactive", int'(misoOut), 0);

    startSession();
    sendFrame(8'hAC, 8'h80, 8'h00, 8'h00, "R6 erase locked");
    check("R6 no erase while locked", eraseSeen, 0);
    sendFrame(8'hAC, 8'h52, 8'h11, 8'h22, "R7 bad key");
    check("R7 stays locked", int'(progEnabled), 0);
    sendFrame(8'hAC, 8'h53, 8'hA5, 8'h5A, "R3 unlock");
    check("R3 unlocked", int'(progEnabled), 1);
    sendFrame(8'hAC, 8'h9F, 8'h00, 8'h00, "R5 erase");
    check("R5 one pulse", eraseSeen, 1);
    sendFrame(8'h20, 8'h00, 8'h00, 8'h00, "R8 other cmd");
    check("R8 still unlocked", int'(progEnabled), 1);
    endSession();

    // slip recovery
    startSession();
    sendBit(1'b1, "R7 stray");
    sendFrame(8'hAC, 8'h53, 8'h00, 8'h00, "R7 misaligned");
    check("R7 misaligned unlock rejected", int'(progEnabled), 0);
    for (int i = 0; i < 31; i++) sendBit(1'b0, "R7 realign");
    sendFrame(8'hAC, 8'h53, 8'h00, 8'h00, "R7 retry");
    check("R7 retry unlocks", int'(progEnabled), 1);
    endSession();

    // random sessions
    for (int s = 0; s < 4; s++) begin
      startSession();
      for (int f = 0; f < 14; f++) begin
        int kind;
        kind = $urandom_range(0, 5);
        if ($urandom_range(0, 9) == 0) sendBit(1'($urandom_range(0, 1)), "R7 rand stray");
        case (kind)
          0: sendFrame(8'hAC, 8'h53, 8'($urandom), 8'($urandom), "R3 rand");
          1: sendFrame(8'hAC, {3'b100, 5'($urandom)}, 8'($urandom), 8'($urandom), "R5 rand");
          2: sendFrame(8'hAC, 8'($urandom), 8'($urandom), 8'($urandom), "R6 rand");
          default: sendFrame(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), "R2 rand");
        endcase
      end
      endSession();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule